// File: doc/BRIEF.md
# DMA Global Run-Stop Controller

This block is the global control point of a multi-channel DMA engine. It holds the master enable and a four-bit global hold field, and fans them out to every channel as a run permit, a stop request and a pause request. Each channel answers with a busy flag and a paused flag. From these the block works out when the whole engine has come to rest after software cleared the enable or raised a hold. It shows that in a stopped status bit that only hardware can change.

Software reaches the state through one 32-bit control word, with address, write-enable, write data and byte strobes. A read returns its data one cycle after the request. The stopped bit is armed only when the engine leaves its running condition (enable set and hold zero). It then sets when the channels have settled. It clears as soon as the running condition holds again. CPU writes never change it.

Top module: `dma_runstop_ctrl`

## Requirements
- R1: After reset the enable is 0, the hold field is 0000, the stopped bit is 0, `reg_rvalid` is 0 and a read of the control word returns 0.
- R2: In the control word (address `CTRL_ADDR`), bit 31 is the enable and bits 27:24 are the hold field. Both are written only when `reg_be[3]` is 1. All other bits read 0 and ignore writes. Any other address reads 0 and ignores writes.
- R3: Bit 30 of the control word is the stopped status. Writing 0 or 1 to it leaves its value unchanged.
- R4: A read request in one cycle gives `reg_rvalid` high and the read data in the next cycle only.
- R5: Every bit of `ch_run_ok` is 1 exactly when the enable is 1 and the hold field is 0000. Otherwise every bit is 0.
- R6: Every bit of `ch_stop_req` is 1 while the enable is 0, so that any channel in mid-transfer aborts.
- R7: Every bit of `ch_pause_req` is 1 while the enable is 1 and the hold field is not 0000.
- R8: After the enable is cleared from the running condition, the stopped bit stays 0 while any `ch_busy` bit is 1. It becomes 1 at the clock edge after the last busy bit drops.
- R9: After a non-zero hold is written from the running condition, the stopped bit sets at the clock edge after every channel is either not busy or paused. It stays 0 while any channel is busy and not paused.
- R10: The stopped bit returns to 0 at the first clock edge after the enable is 1 and the hold field is 0000. Once set, it stays 1 until then.
- R11: The stopped bit does not set after reset unless the engine has first left the running condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write request |
| reg_rd | input | 1 | Read request |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte strobes for the write |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| ch_busy | input | NUM_CH | Channel is moving data |
| ch_paused | input | NUM_CH | Channel has reached its paused state |
| ch_run_ok | output | NUM_CH | Channel may run |
| ch_stop_req | output | NUM_CH | Channel must abort and stop |
| ch_pause_req | output | NUM_CH | Channel must pause |

## Verification
The part of the state that can go wrong is the armed flag and the stopped bit, and both are visible only through a read of bit 30. A stopped bit that sets one edge early or late shows up in a read issued in the same cycle as the last busy drop: that read must return 0, and the read after it must return 1. A wrongly armed flag shows up as a 1 read back a few cycles after reset with all channels idle. A broken field decode shows up straight away on the three per-channel request vectors, in the cycle after the write.

// File: rtl/dma_rs_pkg.sv
package dma_rs_pkg;

   localparam int REG_W     = 32;
   localparam int EN_BIT    = 31;
   localparam int ST_BIT    = 30;
   localparam int HOLD_LSB  = 24;
   localparam int HOLD_W    = 4;
   localparam int CTL_BYTE  = 3;

   typedef struct packed {
      logic              en;
      logic [HOLD_W-1:0] hold;
   } ctl_t;

   // Engine is in its running condition: enabled and no hold pending.
   function automatic logic ctl_runs(ctl_t c);
      return c.en && (c.hold == '0);
   endfunction

   // Build the visible control word from the stored fields and status.
   function automatic logic [REG_W-1:0] ctl_word(ctl_t c, logic stopped);
      logic [REG_W-1:0] w;
      w = '0;
      w[EN_BIT]                = c.en;
      w[ST_BIT]                = stopped;
      w[HOLD_LSB +: HOLD_W]    = c.hold;
      return w;
   endfunction

endpackage

// File: rtl/dma_rs_cfg.sv
module dma_rs_cfg
   import dma_rs_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int CTRL_ADDR = 0
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [REG_W-1:0]    reg_wdata,
   input  logic [REG_W/8-1:0]  reg_be,
   input  logic                stat_i,
   output ctl_t                ctl_q,
   output ctl_t                ctl_d,
   output logic [REG_W-1:0]    reg_rdata,
   output logic                reg_rvalid
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   logic hit_wr;
   logic hit_rd;
   logic byte_wr;

   assign hit_wr  = reg_wr && (reg_addr == CTRL_A);
   assign hit_rd  = reg_rd && (reg_addr == CTRL_A);
   assign byte_wr = hit_wr && reg_be[CTL_BYTE];

   // Next value of the software-owned fields; the status bit is never taken.
   always_comb begin
      ctl_d = ctl_q;
      if (byte_wr) begin
         ctl_d.en   = reg_wdata[EN_BIT];
         ctl_d.hold = reg_wdata[HOLD_LSB +: HOLD_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         ctl_q <= ctl_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
      end else begin
         reg_rvalid <= reg_rd;
         reg_rdata  <= hit_rd ? ctl_word(ctl_q, stat_i) : '0;
      end
   end

   logic unused_wbits;
   assign unused_wbits = ^{reg_wdata[ST_BIT], reg_wdata[HOLD_LSB+HOLD_W +: 2],
                           reg_wdata[HOLD_LSB-1:0], reg_be[CTL_BYTE-1:0]};

endmodule

// File: rtl/dma_rs_fanout.sv
module dma_rs_fanout
   import dma_rs_pkg::*;
#(
   parameter int NUM_CH = 8
)(
   input  ctl_t              ctl_q,
   output logic [NUM_CH-1:0] ch_run_ok,
   output logic [NUM_CH-1:0] ch_stop_req,
   output logic [NUM_CH-1:0] ch_pause_req
);

   logic run_all;
   logic stop_all;
   logic pause_all;

   assign run_all   = ctl_runs(ctl_q);
   assign stop_all  = !ctl_q.en;
   assign pause_all = ctl_q.en && (ctl_q.hold != '0);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign ch_run_ok[i]    = run_all;
      assign ch_stop_req[i]  = stop_all;
      assign ch_pause_req[i] = pause_all;
   end

endmodule

// File: rtl/dma_rs_quiesce.sv
module dma_rs_quiesce
   import dma_rs_pkg::*;
#(
   parameter int NUM_CH = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl_q,
   input  ctl_t              ctl_d,
   input  logic [NUM_CH-1:0] ch_busy,
   input  logic [NUM_CH-1:0] ch_paused,
   output logic              stat_q
);

   logic [NUM_CH-1:0] idle_v;
   logic [NUM_CH-1:0] parked_v;
   logic              settled;
   logic              armed_q;
   logic              run_now;
   logic              run_next;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign idle_v[i]   = !ch_busy[i];
      assign parked_v[i] = !ch_busy[i] || ch_paused[i];
   end

   assign run_now  = ctl_runs(ctl_q);
   assign run_next = ctl_runs(ctl_d);
   // Disabled: wait for every channel to go idle. Held: idle or paused.
   assign settled  = ctl_q.en ? (&parked_v) : (&idle_v);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (run_now) begin
         armed_q <= !run_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= 1'b0;
      end else if (run_now) begin
         stat_q <= 1'b0;
      end else if (armed_q && settled) begin
         stat_q <= 1'b1;
      end
   end

endmodule

// File: rtl/dma_runstop_ctrl.sv
module dma_runstop_ctrl
   import dma_rs_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter int ADDR_W    = 4,
   parameter int CTRL_ADDR = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   input  logic [3:0]        reg_be,
   output logic [31:0]       reg_rdata,
   output logic              reg_rvalid,
   input  logic [NUM_CH-1:0] ch_busy,
   input  logic [NUM_CH-1:0] ch_paused,
   output logic [NUM_CH-1:0] ch_run_ok,
   output logic [NUM_CH-1:0] ch_stop_req,
   output logic [NUM_CH-1:0] ch_pause_req
);

   if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_nch
      $error("NUM_CH must lie in 1..64");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W must lie in 1..16");
   end
   if (CTRL_ADDR < 0 || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("CTRL_ADDR does not fit in ADDR_W bits");
   end

   ctl_t ctl_q;
   ctl_t ctl_d;
   logic stat_q;

   dma_rs_cfg #(
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_addr   (reg_addr),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_wdata  (reg_wdata),
      .reg_be     (reg_be),
      .stat_i     (stat_q),
      .ctl_q      (ctl_q),
      .ctl_d      (ctl_d),
      .reg_rdata  (reg_rdata),
      .reg_rvalid (reg_rvalid)
   );

   dma_rs_quiesce #(
      .NUM_CH (NUM_CH)
   ) u_quiesce (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_q     (ctl_q),
      .ctl_d     (ctl_d),
      .ch_busy   (ch_busy),
      .ch_paused (ch_paused),
      .stat_q    (stat_q)
   );

   dma_rs_fanout #(
      .NUM_CH (NUM_CH)
   ) u_fanout (
      .ctl_q        (ctl_q),
      .ch_run_ok    (ch_run_ok),
      .ch_stop_req  (ch_stop_req),
      .ch_pause_req (ch_pause_req)
   );

endmodule

// File: rtl/dma_rs_chk.sv
module dma_rs_chk #(
   parameter int NUM_CH = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_rd,
   input logic              reg_rvalid,
   input logic              stat,
   input logic [NUM_CH-1:0] ch_busy,
   input logic [NUM_CH-1:0] ch_paused,
   input logic [NUM_CH-1:0] ch_run_ok,
   input logic [NUM_CH-1:0] ch_stop_req,
   input logic [NUM_CH-1:0] ch_pause_req
);

   a_r4_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid);

   a_r4_rvalid_only: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> !reg_rvalid);

   a_r5_run_excludes_req: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run_ok != '0) |-> (ch_stop_req == '0 && ch_pause_req == '0));

   a_r6_stop_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_stop_req == '0) || (ch_stop_req == '1));

   a_r8_stop_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stat) && $past(ch_pause_req) == '0) |-> ($past(ch_busy) == '0));

   a_r9_stop_after_park: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stat) && $past(ch_pause_req) != '0)
         |-> ($past(ch_busy & ~ch_paused) == '0));

   a_r10_clear_on_run: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run_ok != '0) |=> !stat);

endmodule

bind dma_runstop_ctrl dma_rs_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_rd       (reg_rd),
   .reg_rvalid   (reg_rvalid),
   .stat         (stat_q),
   .ch_busy      (ch_busy),
   .ch_paused    (ch_paused),
   .ch_run_ok    (ch_run_ok),
   .ch_stop_req  (ch_stop_req),
   .ch_pause_req (ch_pause_req)
);

// File: tb/dma_runstop_ctrl_tb.sv
module dma_runstop_ctrl_tb;

   localparam int CLK_P  = 10;
   localparam int NUM_CH = 8;
   localparam int ADDR_W = 4;
   localparam int NV     = 7;

   localparam logic [31:0] V_WD [NV] = '{32'h8000_0000, 32'h8300_0000, 32'h4000_0000,
      32'h8000_0000, 32'hFFFF_FFFF, 32'h80FF_FFFF, 32'h0000_0000};
   localparam logic [3:0]  V_BE [NV] = '{4'hF, 4'hF, 4'hF, 4'h7, 4'hF, 4'hF, 4'hF};
   localparam logic [31:0] V_RD [NV] = '{32'h8000_0000, 32'hC300_0000, 32'h4000_0000,
      32'h4000_0000, 32'hCF00_0000, 32'h8000_0000, 32'h4000_0000};
   localparam logic        V_RUN [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
   localparam logic        V_STP [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
   localparam logic        V_PSE [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
   localparam string       V_TAG [NV] = '{"R5", "R9", "R3", "R2", "R7", "R10", "R8"};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic              reg_wr = 1'b0;
   logic              reg_rd = 1'b0;
   logic [31:0]       reg_wdata = '0;
   logic [3:0]        reg_be = '0;
   logic [31:0]       reg_rdata;
   logic              reg_rvalid;
   logic [NUM_CH-1:0] ch_busy = '0;
   logic [NUM_CH-1:0] ch_paused = '0;
   logic [NUM_CH-1:0] ch_run_ok;
   logic [NUM_CH-1:0] ch_stop_req;
   logic [NUM_CH-1:0] ch_pause_req;

   int checks = 0;
   int fails  = 0;
   logic [31:0] rv;

   always #(CLK_P/2) clk = ~clk;

   dma_runstop_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CTRL_ADDR(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
      .reg_rvalid(reg_rvalid), .ch_busy(ch_busy), .ch_paused(ch_paused),
      .ch_run_ok(ch_run_ok), .ch_stop_req(ch_stop_req), .ch_pause_req(ch_pause_req));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_ch(input string tag, input logic run, input logic stp, input logic pse);
      check({tag, " run_ok"},    32'(ch_run_ok),    run ? 32'(NUM_CH'('1)) : 32'h0);
      check({tag, " stop_req"},  32'(ch_stop_req),  stp ? 32'(NUM_CH'('1)) : 32'h0);
      check({tag, " pause_req"}, 32'(ch_pause_req), pse ? 32'(NUM_CH'('1)) : 32'h0);
   endtask

   // Called at a falling edge; returns at the falling edge after the write edge.
   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] b);
      reg_addr = a; reg_wdata = d; reg_be = b; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = '0;
   endtask

   // Called at a falling edge; the data is captured at the next rising edge. R4
   task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
      check("R4 rvalid with data", 32'(reg_rvalid), 32'h1);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 50000);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(4);
      // R1 / R11: reset state, nothing arms with all channels idle.
      check("R1 rvalid", 32'(reg_rvalid), 32'h0);
      check_ch("R1 R6", 1'b0, 1'b1, 1'b0);
      rd(0, rv);
      check("R11 stopped after reset", rv, 32'h0);

      // Table walk: write, settle, read back, check fan-out.
      for (int i = 0; i < NV; i++) begin
         wr(0, V_WD[i], V_BE[i]);
         check_ch(V_TAG[i], V_RUN[i], V_STP[i], V_PSE[i]);
         idle(1);
         rd(0, rv);
         check({V_TAG[i], " readback"}, rv, V_RD[i]);
      end

      // R2: other address ignores writes, reads zero.
      wr(1, 32'hFFFF_FFFF, 4'hF);
      rd(1, rv);
      check("R2 other addr", rv, 32'h0);
      rd(0, rv);
      check("R2 ctrl untouched", rv, 32'h4000_0000);
      @(negedge clk);
      check("R4 rvalid drops", 32'(reg_rvalid), 32'h0);

      // R8: disable with busy channels; exact set cycle.
      ch_busy = 8'hA5;
      wr(0, 32'h8000_0000, 4'hF);
      check_ch("R5 run", 1'b1, 1'b0, 1'b0);
      wr(0, 32'h0000_0000, 4'hF);
      check_ch("R6 disable", 1'b0, 1'b1, 1'b0);
      idle(2);
      rd(0, rv);
      check("R8 busy holds stop", rv, 32'h0);
      ch_busy = 8'h80;
      idle(1);
      rd(0, rv);
      check("R8 one busy left", rv, 32'h0);
      ch_busy = '0;
      rd(0, rv);
      check("R8 same edge as drop", rv, 32'h0);
      rd(0, rv);
      check("R8 set after drop", rv, 32'h4000_0000);

      // R10: re-enable clears stopped one edge later.
      wr(0, 32'h8000_0000, 4'hF);
      check_ch("R10 run", 1'b1, 1'b0, 1'b0);
      idle(1);
      rd(0, rv);
      check("R10 cleared", rv, 32'h8000_0000);

      // R9: hold with mixed busy/paused channels.
      ch_busy = 8'hFF; ch_paused = 8'h00;
      wr(0, 32'h8100_0000, 4'hF);
      check_ch("R7 hold", 1'b0, 1'b0, 1'b1);
      idle(1);
      rd(0, rv);
      check("R9 all busy", rv, 32'h8100_0000);
      ch_paused = 8'h0F;
      idle(1);
      rd(0, rv);
      check("R9 half paused", rv, 32'h8100_0000);
      ch_busy = 8'h0F;
      idle(1);
      rd(0, rv);
      check("R9 settled", rv, 32'hC100_0000);
      // R3: status write ignored while held.
      wr(0, 32'h8100_0000, 4'hF);
      idle(1);
      rd(0, rv);
      check("R3 status kept", rv, 32'hC100_0000);

      // R11: a fresh reset with idle channels does not arm.
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      ch_busy = '0; ch_paused = '0;
      idle(4);
      check_ch("R11 R6 post reset", 1'b0, 1'b1, 1'b0);
      rd(0, rv);
      check("R11 no spurious stop", rv, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule